// File: doc/BRIEF.md
# Three-Button Serial Mouse Packet Encoder

This block sits between a pointer event source and a serial receive path. It sums signed horizontal and vertical motion deltas and tracks the state of three buttons. On a sync strobe it turns that state into a five-byte mouse report and writes the report into a small circular byte queue. A consumer drains the queue one byte at a time through a pop strobe. A data-available flag stays high while the queue holds anything.

Motion larger than one report can carry is not lost. Each axis is limited to plus or minus 127 per report, and whatever is left stays in the accumulator for the next sync. The report begins with a start byte that holds the button state inverted, so a pressed button reads as 0. The X and Y bytes follow, then two zero bytes. The encoder writes one byte per clock. The queue drops bytes it has no room for.

Top module: `mouse_pkt_enc`

## Requirements
- R1: After reset the queue is empty, `rd_avail` is 0, `rd_data` is 0 and no report is in progress.
- R2: A `dx` delta with `dx_valid` is added to the X accumulator. A `dy` delta with `dy_valid` is subtracted from the Y accumulator, so a positive `dy` yields a negative Y byte.
- R3: `btn_sel` 0 selects the left button (mask 0x04), 1 the middle button (0x02) and 2 the right button (0x01). `btn_down` 1 presses the button and 0 releases it, and either event sets a change flag. `btn_sel` 3 changes nothing and does not set the flag. The start byte is 0x87 XOR the mask of pressed buttons.
- R4: A sync with both accumulators at zero and the change flag clear produces no bytes.
- R5: The X and Y bytes are each accumulator clamped to the range -127..+127, in two's complement, so 0x80 never appears. The clamped amount is subtracted from the accumulator and the remainder is carried over to the next report.
- R6: A report is written in the order start byte, X, Y, 0x00, 0x00. The five bytes go out on five consecutive cycles, starting the cycle after the sync is accepted.
- R7: The queue holds 16 bytes. A byte arriving while it is full is discarded, and the bytes already stored are kept.
- R8: `rd_data` shows the oldest byte while `rd_avail` is 1 and shows 0 when the queue is empty. A pop on an empty queue has no effect.
- R9: A sync that arrives while a report is still being written is ignored, and the accumulators keep their values.
- R10: The accumulators are 16-bit signed and saturate at +32767 and -32768.
- R11: An accepted sync clears the change flag. A following sync with no new motion and no new button event produces no bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dx_valid | input | 1 | `dx` holds a delta this cycle |
| dx | input | 8 | Signed horizontal delta |
| dy_valid | input | 1 | `dy` holds a delta this cycle |
| dy | input | 8 | Signed vertical delta |
| btn_valid | input | 1 | Button event this cycle |
| btn_sel | input | 2 | Button select: 0 left, 1 middle, 2 right, 3 none |
| btn_down | input | 1 | 1 for a press, 0 for a release |
| sync | input | 1 | Request a report |
| pop | input | 1 | Remove the oldest queued byte |
| rd_data | output | 8 | Oldest queued byte, or 0 when empty |
| rd_avail | output | 1 | Queue is not empty |

## Verification
The bench sweeps every signed delta value on both axes and every combination of the three buttons. The extreme values would expose a design that lets -128 through the clamp, or one that adds Y without negating it; a wrong button mapping would show up as a bad start byte. Long runs of maximum deltas drive both accumulators into saturation, and the drain that follows checks that each remainder survives exactly. A design that wraps or drops residual motion would emit a wrong final report. The remaining tests overfill the queue, pop an empty queue, send a second sync during a report and send a sync with nothing pending. A design that overwrote stored bytes, corrupted its pointers, restarted a report or emitted an empty report would each show a byte stream different from the one the bench expects.

// File: rtl/mpe_pkg.sv
`timescale 1ns/1ps
package mpe_pkg;
  localparam int BYTE_W   = 8;
  localparam int PKT_LEN  = 5;
  localparam int IDX_W    = $clog2(PKT_LEN);
  localparam logic [BYTE_W-1:0] START_BASE = 8'h87;
  localparam int CLAMP_MAG = 127;

  // button select code to mask bit: left 0x4, middle 0x2, right 0x1
  function automatic logic [2:0] sel_mask(input logic [1:0] sel);
    case (sel)
      2'd0:    sel_mask = 3'b100;
      2'd1:    sel_mask = 3'b010;
      2'd2:    sel_mask = 3'b001;
      default: sel_mask = 3'b000;
    endcase
  endfunction
endpackage

// File: rtl/mpe_axis_acc.sv
`timescale 1ns/1ps
module mpe_axis_acc #(
  parameter int ACC_W   = 16,
  parameter int DELTA_W = 8,
  parameter bit NEGATE  = 1'b0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic signed [DELTA_W-1:0] in_delta,
  input  logic                      take,
  output logic [7:0]                clamp_out,
  output logic                      nonzero
);
  localparam int SUM_W = ACC_W + 2;
  localparam logic signed [SUM_W-1:0] SUM_MAX = SUM_W'((1 << (ACC_W-1)) - 1);
  localparam logic signed [SUM_W-1:0] SUM_MIN = -SUM_MAX - 1;
  localparam logic signed [ACC_W-1:0] CL_POS  = ACC_W'(mpe_pkg::CLAMP_MAG);
  localparam logic signed [ACC_W-1:0] CL_NEG  = -CL_POS;

  logic signed [ACC_W-1:0] acc_q, acc_d, clamp_v;
  logic signed [SUM_W-1:0] ext_delta, ext_take, sum;

  always_comb begin
    if (acc_q > CL_POS)      clamp_v = CL_POS;
    else if (acc_q < CL_NEG) clamp_v = CL_NEG;
    else                     clamp_v = acc_q;

    ext_delta = {{(SUM_W-DELTA_W){in_delta[DELTA_W-1]}}, in_delta};
    if (NEGATE) ext_delta = -ext_delta;
    if (!in_valid) ext_delta = '0;
    ext_take = take ? {{(SUM_W-ACC_W){clamp_v[ACC_W-1]}}, clamp_v} : '0;

    sum = {{(SUM_W-ACC_W){acc_q[ACC_W-1]}}, acc_q} + ext_delta - ext_take;
    if (sum > SUM_MAX)      acc_d = SUM_MAX[ACC_W-1:0];
    else if (sum < SUM_MIN) acc_d = SUM_MIN[ACC_W-1:0];
    else                    acc_d = sum[ACC_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               acc_q <= '0;
    else if (in_valid || take) acc_q <= acc_d;
  end

  assign clamp_out = clamp_v[7:0];
  assign nonzero   = (acc_q != '0);
endmodule

// File: rtl/mpe_buttons.sv
`timescale 1ns/1ps
module mpe_buttons (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       btn_valid,
  input  logic [1:0] btn_sel,
  input  logic       btn_down,
  input  logic       clear_chg,
  output logic [2:0] mask,
  output logic       chg
);
  logic [2:0] mask_q, mask_d, sel_bit;
  logic       chg_q, chg_d, ev_ok;

  always_comb begin
    sel_bit = mpe_pkg::sel_mask(btn_sel);
    ev_ok   = btn_valid && (sel_bit != 3'b000);
    mask_d  = mask_q;
    if (ev_ok) mask_d = btn_down ? (mask_q | sel_bit) : (mask_q & ~sel_bit);
    // an event in the same cycle as an accepted sync keeps the flag set
    chg_d = ev_ok ? 1'b1 : (clear_chg ? 1'b0 : chg_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      chg_q  <= 1'b0;
    end else begin
      if (ev_ok) mask_q <= mask_d;
      if (ev_ok || clear_chg) chg_q <= chg_d;
    end
  end

  assign mask = mask_q;
  assign chg  = chg_q;
endmodule

// File: rtl/mpe_seq.sv
`timescale 1ns/1ps
module mpe_seq
  import mpe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync,
  input  logic              x_nz,
  input  logic              y_nz,
  input  logic              chg,
  input  logic [2:0]        mask,
  input  logic [7:0]        x_cl,
  input  logic [7:0]        y_cl,
  input  logic              push_ready,
  output logic              take,
  output logic              push_valid,
  output logic [7:0]        push_data,
  output logic              busy,
  output logic [IDX_W-1:0]  idx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(PKT_LEN - 1);

  logic             busy_q, busy_d, accept;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [7:0]       st_q, st_d, x_q, x_d, y_q, y_d;

  always_comb begin
    accept = sync && !busy_q && (x_nz || y_nz || chg);
    busy_d = busy_q;
    idx_d  = idx_q;
    st_d   = st_q;
    x_d    = x_q;
    y_d    = y_q;
    if (accept) begin
      busy_d = 1'b1;
      idx_d  = '0;
      st_d   = START_BASE ^ {5'b00000, mask};
      x_d    = x_cl;
      y_d    = y_cl;
    end else if (busy_q && push_ready) begin
      if (idx_q == LAST) busy_d = 1'b0;
      else               idx_d  = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      st_q   <= '0;
      x_q    <= '0;
      y_q    <= '0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
      if (accept) begin
        st_q <= st_d;
        x_q  <= x_d;
        y_q  <= y_d;
      end
    end
  end

  always_comb begin
    case (idx_q)
      3'd0:    push_data = st_q;
      3'd1:    push_data = x_q;
      3'd2:    push_data = y_q;
      default: push_data = 8'h00;
    endcase
  end

  assign take       = accept;
  assign push_valid = busy_q;
  assign busy       = busy_q;
  assign idx        = idx_q;
endmodule

// File: rtl/mpe_queue.sv
`timescale 1ns/1ps
module mpe_queue #(
  parameter int DEPTH = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      push_valid,
  input  logic [7:0]                push_data,
  output logic                      push_ready,
  input  logic                      pop,
  output logic [7:0]                rd_data,
  output logic                      rd_avail,
  output logic [$clog2(DEPTH):0]    count
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam logic [PTR_W:0]   FULL_CNT = (PTR_W+1)'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_P   = PTR_W'(DEPTH - 1);

  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [PTR_W:0]   cnt_q, cnt_d;
  logic             do_wr, do_rd;

  always_comb begin
    do_wr = push_valid && (cnt_q != FULL_CNT);
    do_rd = pop && (cnt_q != '0);
    wp_d  = do_wr ? ((wp_q == LAST_P) ? '0 : wp_q + 1'b1) : wp_q;
    rp_d  = do_rd ? ((rp_q == LAST_P) ? '0 : rp_q + 1'b1) : rp_q;
    cnt_d = cnt_q + {{PTR_W{1'b0}}, do_wr} - {{PTR_W{1'b0}}, do_rd};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp_q] <= push_data;
  end

  assign push_ready = 1'b1;  // always takes the byte; drops it when full
  assign rd_avail   = (cnt_q != '0);
  assign rd_data    = rd_avail ? mem[rp_q] : 8'h00;
  assign count      = cnt_q;
endmodule

// File: rtl/mouse_pkt_enc.sv
`timescale 1ns/1ps
module mouse_pkt_enc #(
  parameter int ACC_W   = 16,
  parameter int DELTA_W = 8,
  parameter int DEPTH   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dx_valid,
  input  logic [DELTA_W-1:0] dx,
  input  logic               dy_valid,
  input  logic [DELTA_W-1:0] dy,
  input  logic               btn_valid,
  input  logic [1:0]         btn_sel,
  input  logic               btn_down,
  input  logic               sync,
  input  logic               pop,
  output logic [7:0]         rd_data,
  output logic               rd_avail
);
  localparam int CNT_W = $clog2(DEPTH) + 1;

  logic [7:0]               x_cl, y_cl, push_data;
  logic                     x_nz, y_nz, take, chg, push_valid, push_ready, seq_busy;
  logic [2:0]               mask;
  logic [mpe_pkg::IDX_W-1:0] seq_idx;
  logic [CNT_W-1:0]         q_count;

  mpe_axis_acc #(.ACC_W(ACC_W), .DELTA_W(DELTA_W), .NEGATE(1'b0)) u_xacc (
    .clk(clk), .rst_n(rst_n), .in_valid(dx_valid), .in_delta(dx),
    .take(take), .clamp_out(x_cl), .nonzero(x_nz));

  mpe_axis_acc #(.ACC_W(ACC_W), .DELTA_W(DELTA_W), .NEGATE(1'b1)) u_yacc (
    .clk(clk), .rst_n(rst_n), .in_valid(dy_valid), .in_delta(dy),
    .take(take), .clamp_out(y_cl), .nonzero(y_nz));

  mpe_buttons u_btn (
    .clk(clk), .rst_n(rst_n), .btn_valid(btn_valid), .btn_sel(btn_sel),
    .btn_down(btn_down), .clear_chg(take), .mask(mask), .chg(chg));

  mpe_seq u_seq (
    .clk(clk), .rst_n(rst_n), .sync(sync), .x_nz(x_nz), .y_nz(y_nz),
    .chg(chg), .mask(mask), .x_cl(x_cl), .y_cl(y_cl),
    .push_ready(push_ready), .take(take), .push_valid(push_valid),
    .push_data(push_data), .busy(seq_busy), .idx(seq_idx));

  mpe_queue #(.DEPTH(DEPTH)) u_q (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_data(push_data),
    .push_ready(push_ready), .pop(pop), .rd_data(rd_data),
    .rd_avail(rd_avail), .count(q_count));
endmodule

// File: rtl/mpe_checker.sv
`timescale 1ns/1ps
module mpe_checker #(
  parameter int DEPTH = 16
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      sync,
  input logic                      pop,
  input logic                      rd_avail,
  input logic                      busy,
  input logic [mpe_pkg::IDX_W-1:0] idx,
  input logic                      push_valid,
  input logic [7:0]                push_data,
  input logic [$clog2(DEPTH):0]    q_count
);
  // R7: the stored count never exceeds the depth
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= ($clog2(DEPTH)+1)'(DEPTH));

  // R8: popping an empty queue with no byte arriving leaves it empty
  a_r8_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_avail && pop && !push_valid) |=> !rd_avail);

  // R5: the clamped X byte is never -128
  a_r5_clamp_x: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && idx == 3'd1) |-> push_data != 8'h80);

  // R9: once started a report runs to its last byte, whatever sync does
  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && idx != 3'd4) |=> (busy && idx == $past(idx) + 3'd1));

  // R3: the first byte of each report has the form 1000_0bbb
  a_r3_start_form: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> push_data[7:3] == 5'b10000);

  // R6: the two trailing bytes are zero
  a_r6_tail_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && idx >= 3'd3) |-> push_data == 8'h00);
endmodule

bind mouse_pkt_enc mpe_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .sync(sync), .pop(pop), .rd_avail(rd_avail),
  .busy(seq_busy), .idx(seq_idx), .push_valid(push_valid),
  .push_data(push_data), .q_count(q_count));

// File: tb/sim_mouse_pkt_enc.sv
`timescale 1ns/1ps
module sim_mouse_pkt_enc;
  logic       clk, rst_n;
  logic       dx_valid, dy_valid, btn_valid, btn_down, sync, pop;
  logic [7:0] dx, dy, rd_data;
  logic [1:0] btn_sel;
  logic       rd_avail;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model
  int ax = 0, ay = 0, mmask = 0;
  bit mchg = 0;
  int mq [16];
  int mhead = 0, mcnt = 0;

  mouse_pkt_enc u0 (.clk(clk), .rst_n(rst_n), .dx_valid(dx_valid), .dx(dx),
    .dy_valid(dy_valid), .dy(dy), .btn_valid(btn_valid), .btn_sel(btn_sel),
    .btn_down(btn_down), .sync(sync), .pop(pop), .rd_data(rd_data),
    .rd_avail(rd_avail));

  initial clk = 0;
  always #2.5 clk = ~clk;

  function automatic int sat16(input int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic int clamp127(input int v);
    if (v > 127) return 127;
    if (v < -127) return -127;
    return v;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_push(input int b);
    if (mcnt < 16) begin
      mq[(mhead + mcnt) % 16] = b;
      mcnt++;
    end
  endtask

  task automatic motion(input int x, input int y);
    dx_valid = 1; dx = x[7:0];
    dy_valid = 1; dy = y[7:0];
    @(negedge clk);
    dx_valid = 0; dy_valid = 0;
    ax = sat16(ax + x);
    ay = sat16(ay - y);
  endtask

  task automatic button(input int sel, input bit down);
    int bitv;
    btn_valid = 1; btn_sel = sel[1:0]; btn_down = down;
    @(negedge clk);
    btn_valid = 0;
    bitv = (sel == 0) ? 4 : (sel == 1) ? 2 : (sel == 2) ? 1 : 0;
    if (bitv != 0) begin
      mmask = down ? (mmask | bitv) : (mmask & ~bitv);
      mchg = 1;
    end
  endtask

  task automatic model_report();
    int cx, cy;
    if (ax != 0 || ay != 0 || mchg) begin
      cx = clamp127(ax); cy = clamp127(ay);
      ax = ax - cx; ay = ay - cy;
      mchg = 0;
      model_push(8'h87 ^ mmask);
      model_push(cx & 255);
      model_push(cy & 255);
      model_push(0);
      model_push(0);
    end
  endtask

  task automatic do_sync();
    sync = 1;
    @(negedge clk);
    sync = 0;
    model_report();
    repeat (6) @(negedge clk);
  endtask

  task automatic drain(input string req);
    while (mcnt > 0) begin
      check(req, rd_avail, 1);
      check(req, rd_data, mq[mhead]);
      pop = 1;
      @(negedge clk);
      pop = 0;
      mhead = (mhead + 1) % 16;
      mcnt--;
    end
    check(req, rd_avail, 0);
    check(req, rd_data, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; dx_valid = 0; dy_valid = 0; btn_valid = 0; btn_down = 0;
    btn_sel = 0; sync = 0; pop = 0; dx = 0; dy = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1", rd_avail, 0);
    check("R1", rd_data, 0);

    // R4 sync with nothing pending
    do_sync();
    check("R4", rd_avail, 0);

    // R2 X adds, Y negated; R6 order and trailing zeros
    motion(10, 5); motion(20, 0);
    do_sync();
    check("R6", mcnt, 5);
    drain("R2");

    // R3 left press, no motion
    button(0, 1);
    do_sync();
    check("R3", mq[mhead], 8'h83);
    drain("R3");
    // R11 flag cleared: no new event means no report
    do_sync();
    check("R11", rd_avail, 0);
    // R3 unsupported select has no effect
    button(3, 1);
    do_sync();
    check("R3", rd_avail, 0);
    button(0, 0);

    // R3 every button combination
    for (int m = 0; m < 8; m++) begin
      button(0, m[2]); button(1, m[1]); button(2, m[0]);
      do_sync();
      check("R3", mq[mhead], 8'h87 ^ m);
      drain("R3");
    end

    // R5 clamp and carry-over
    motion(100, -100); motion(100, -100); motion(100, -100);
    for (int k = 0; k < 3; k++) begin
      do_sync();
      drain("R5");
    end
    check("R5", ax, 0);

    // full sweep of delta values on both axes
    for (int v = -128; v < 128; v++) begin
      motion(v, v);
      do_sync();
      drain("R5");
    end
    while (ax != 0 || ay != 0) begin
      do_sync();
      drain("R5");
    end

    // R9 second sync during a report is ignored
    motion(100, 0); motion(100, 0);
    sync = 1; @(negedge clk);
    model_report();
    @(negedge clk);          // sync still high, report in progress
    sync = 0;
    repeat (6) @(negedge clk);
    check("R9", mcnt, 5);
    drain("R9");
    do_sync();
    check("R9", mq[(mhead + 1) % 16], 73);
    drain("R9");

    // R8 pop on empty, then queue still ordered
    pop = 1; @(negedge clk); pop = 0;
    check("R8", rd_avail, 0);
    check("R8", rd_data, 0);
    motion(3, 4);
    do_sync();
    drain("R8");

    // R7 overfill: four reports, 20 bytes, only 16 kept
    for (int k = 0; k < 4; k++) begin
      motion(k + 1, 0);
      do_sync();
    end
    check("R7", mcnt, 16);
    drain("R7");

    // R10 saturation of both accumulators, then drain remainders
    for (int k = 0; k < 300; k++) motion(127, 127);
    check("R10", ax, 32767);
    check("R10", ay, -32768);
    while (ax != 0 || ay != 0) begin
      do_sync();
      drain("R10");
    end
    do_sync();
    check("R10", rd_avail, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule